// File: doc/BRIEF.md
# Hash Accelerator Register Front-End

This block is the software-facing register window of a block hashing engine that runs either SHA-1 or MD5. It sits between a simple 32-bit register bus and a compression core that lives outside the block. Software chooses the algorithm, says whether the block is the first block (so the core loads its initial constants) or the last one (so the core closes the hash), and gives the block's byte length. It can also restore a running byte count so that a hash interrupted earlier can resume. It then fills a sixteen-word data window. The word that completes the block starts the core with a one-cycle pulse. When the core answers with done, the block latches the digest, raises a completion flag and, if enabled, pulls an active-low level interrupt.

Software clears the completion flag by writing one to bit 0 of the control register. Digest words read back byte-swapped within each word for SHA-1 and unchanged for MD5. A soft reset, requested through the configuration register, clears all software-visible state. A status bit reports when that reset has finished.

Top module: `hashfe_top`

## Requirements
- R1: After hardware reset the control register reads 0x00000002: input ready (bit 1) is 1, output ready (bit 0) is 0, and all other fields are 0. The byte count (0x14) reads 0, status (0x64) reads 1 and `irq_n` is 1.
- R2: The revision register at 0x5C reads the major version in bits 7:4 and the minor version in bits 3:0, with zero above.
- R3: With a block length of L bytes in control bits 31:5, a write to data word N (address 0x1C+4N) while input ready is 1 fires the block when N equals ceil(L/4)-1. That index is 0 for L=0 and 15 for L of 64 or more. `core_start` is then high for exactly one cycle, starting the cycle after the write. Writes to earlier words do not start the core. Data words not rewritten since the last soft reset keep their earlier values on `core_block`.
- R4: When a block fires, the core receives the control fields as they stood when the block fired: algorithm from bit 2 (1 = SHA-1, 0 = MD5), constant load from bit 3, close from bit 4 and the length.
- R5: The byte count at 0x14 is writable. The core receives the count as it stood when the block fired, and the register then advances by the block length.
- R6: Input ready reads 0 from the cycle `core_start` is high until the cycle after `core_done`. Data writes in that window do not change `core_block` and start nothing.
- R7: Output ready is set the cycle after `core_done`. Writing 1 to control bit 0 clears it, and writing 0 leaves it set.
- R8: `irq_n` is 0 exactly while output ready and the interrupt enable (config bit 2 at 0x60) are both 1.
- R9: Digest word i (at 0x00+4i) is the core's i-th digest word captured at `core_done`. For SHA-1 it reads byte-reversed. For MD5 it reads unchanged, and word 4 reads 0.
- R10: Writing 1 to config bit 1 starts a soft reset. That bit and a clear status bit 0 both last SRST_CYC cycles. During that window the control fields, output ready, busy state, data words, byte count, digest and config bits are cleared.
- R11: Config bits 0 and 3 are plain storage that reads back. A write whose address bits 1:0 are not 00 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_n | output | 1 | Active-low level completion interrupt |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_sha | output | 1 | Algorithm of the launched block, 1 = SHA-1 |
| core_init | output | 1 | Load initial constants for this block |
| core_close | output | 1 | This block closes the hash |
| core_len | output | 7 | Byte length of the launched block |
| core_count | output | 32 | Byte count the block continues from |
| core_block | output | 512 | Data words, word k at bits 32k+31:32k |
| core_done | input | 1 | Core finished the block |
| core_digest | input | 160 | Digest words, word i at bits 32i+31:32i |

## Verification
The bench builds the block with a three-cycle soft reset. This lets it count the exact number of reads during which status stays low. It uses revision values 5 and 9 so that the two nibbles cannot be confused. A behavioural core with a fixed six-cycle latency answers every start. This keeps the busy window open long enough to push ignored data writes into it and to watch input ready fall and rise. Block lengths of 0, 9, 12 and 64 bytes exercise both clamps of the last-word rule and its rounding.

// File: rtl/hashfe_pkg.sv
package hashfe_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 16;
  localparam int DIG_WORDS = 5;
  localparam int MD5_WORDS = 4;
  localparam int LEN_W     = 7;
  localparam int BIX_W     = $clog2(BLK_WORDS);

  // word indices (byte address / 4); software decodes these positions
  localparam logic [5:0] IX_COUNT = 6'd5;
  localparam logic [5:0] IX_CTRL  = 6'd6;
  localparam logic [5:0] IX_DIN   = 6'd7;
  localparam logic [5:0] IX_DLAST = IX_DIN + 6'(BLK_WORDS - 1);
  localparam logic [5:0] IX_REV   = 6'd23;
  localparam logic [5:0] IX_CFG   = 6'd24;
  localparam logic [5:0] IX_STAT  = 6'd25;

  typedef struct packed {
    logic             sha;
    logic             init;
    logic             close;
    logic [LEN_W-1:0] len;
  } ctl_t;

  // index of the data word that completes a block of len bytes
  function automatic logic [BIX_W-1:0] last_word(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] n;
    n = ({1'b0, len} + (LEN_W+1)'(3)) >> 2;
    if (n == '0) n = (LEN_W+1)'(1);
    if (n > (LEN_W+1)'(BLK_WORDS)) n = (LEN_W+1)'(BLK_WORDS);
    return BIX_W'(n - (LEN_W+1)'(1));
  endfunction

  function automatic logic [WORD_W-1:0] bswap32(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/hashfe_srst.sv
module hashfe_srst #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (kick) begin
      busy <= 1'b1;
      cnt  <= CW'(CYC);
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/hashfe_dwin.sv
module hashfe_dwin import hashfe_pkg::*; (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        we,
  input  logic [BIX_W-1:0]            idx,
  input  logic [WORD_W-1:0]           wdata,
  output logic [BLK_WORDS*WORD_W-1:0] blk
);
  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] w;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             w <= '0;
      else if (clr)                           w <= '0;
      else if (we && idx == BIX_W'(g))        w <= wdata;
    end
    assign blk[g*WORD_W +: WORD_W] = w;
  end
endmodule

// File: rtl/hashfe_seq.sv
module hashfe_seq import hashfe_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ctl_wr,
  input  ctl_t              ctl_wd,
  input  logic              w1c_out,
  input  logic              cnt_wr,
  input  logic [WORD_W-1:0] cnt_wd,
  input  logic              fire,
  input  logic              core_done,
  output ctl_t              ctl,
  output logic              out_ready,
  output logic              in_ready,
  output logic [WORD_W-1:0] count,
  output logic              start,
  output ctl_t              launch,
  output logic [WORD_W-1:0] launch_count
);
  logic busy;
  assign in_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; out_ready <= 1'b0; busy <= 1'b0; count <= '0;
      start <= 1'b0; launch <= '0; launch_count <= '0;
    end else if (clr) begin
      ctl <= '0; out_ready <= 1'b0; busy <= 1'b0; count <= '0;
      start <= 1'b0; launch <= '0; launch_count <= '0;
    end else begin
      start <= fire;
      if (ctl_wr) ctl <= ctl_wd;
      if (core_done && busy)       out_ready <= 1'b1;
      else if (ctl_wr && w1c_out)  out_ready <= 1'b0;
      if (fire)                    busy <= 1'b1;
      else if (core_done)          busy <= 1'b0;
      if (cnt_wr)    count <= cnt_wd;
      else if (fire) count <= count + WORD_W'(ctl.len);
      if (fire) begin
        launch       <= ctl;
        launch_count <= count;
      end
    end
  end
endmodule

// File: rtl/hashfe_digest.sv
module hashfe_digest import hashfe_pkg::*; (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        cap,
  input  logic [DIG_WORDS*WORD_W-1:0] dig_in,
  input  logic                        sha,
  input  logic [2:0]                  rd_idx,
  output logic [WORD_W-1:0]           rd_word
);
  logic [DIG_WORDS*WORD_W-1:0] dig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dig <= '0;
    else if (clr) dig <= '0;
    else if (cap) dig <= dig_in;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < DIG_WORDS; i++) begin
      if (rd_idx == 3'(i)) begin
        if (sha)                rd_word = bswap32(dig[i*WORD_W +: WORD_W]);
        else if (i < MD5_WORDS) rd_word = dig[i*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/hashfe_top.sv
module hashfe_top import hashfe_pkg::*; #(
  parameter int         SRST_CYC  = 8,
  parameter logic [3:0] REV_MAJOR = 4'd2,
  parameter logic [3:0] REV_MINOR = 4'd0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [7:0]                  bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        irq_n,
  output logic                        core_start,
  output logic                        core_sha,
  output logic                        core_init,
  output logic                        core_close,
  output logic [6:0]                  core_len,
  output logic [31:0]                 core_count,
  output logic [511:0]                core_block,
  input  logic                        core_done,
  input  logic [159:0]                core_digest
);
  logic [5:0]       widx;
  logic             aligned, wr_ok;
  logic             sel_din;
  logic [5:0]       din_off;
  logic [BIX_W-1:0] din_idx;
  logic             din_we, fire;
  logic             ctl_wr, cnt_wr, cfg_wr;
  logic             srst_busy, srst_kick;
  logic             cfg_idle, cfg_irq_en, cfg_dma;
  ctl_t             ctl, launch, ctl_wd;
  logic             out_ready, in_ready;
  logic [31:0]      count, dig_word;

  assign widx    = bus_addr[7:2];
  assign aligned = bus_addr[1:0] == 2'b00;
  assign wr_ok   = bus_wr && aligned && !srst_busy;
  assign sel_din = widx >= IX_DIN && widx <= IX_DLAST;
  assign din_off = widx - IX_DIN;
  assign din_idx = din_off[BIX_W-1:0];
  assign din_we  = wr_ok && sel_din && in_ready;
  assign fire    = din_we && din_idx == last_word(ctl.len);
  assign ctl_wr  = wr_ok && widx == IX_CTRL;
  assign cnt_wr  = wr_ok && widx == IX_COUNT;
  assign cfg_wr  = wr_ok && widx == IX_CFG;
  assign srst_kick = cfg_wr && bus_wdata[1];

  assign ctl_wd = '{sha: bus_wdata[2], init: bus_wdata[3], close: bus_wdata[4],
                    len: bus_wdata[5 +: LEN_W]};

  hashfe_srst #(.CYC(SRST_CYC)) u_srst (
    .clk(clk), .rst_n(rst_n), .kick(srst_kick), .busy(srst_busy));

  hashfe_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clr(srst_busy),
    .ctl_wr(ctl_wr), .ctl_wd(ctl_wd), .w1c_out(bus_wdata[0]),
    .cnt_wr(cnt_wr), .cnt_wd(bus_wdata), .fire(fire), .core_done(core_done),
    .ctl(ctl), .out_ready(out_ready), .in_ready(in_ready), .count(count),
    .start(core_start), .launch(launch), .launch_count(core_count));

  hashfe_dwin u_dwin (
    .clk(clk), .rst_n(rst_n), .clr(srst_busy), .we(din_we), .idx(din_idx),
    .wdata(bus_wdata), .blk(core_block));

  hashfe_digest u_dig (
    .clk(clk), .rst_n(rst_n), .clr(srst_busy), .cap(core_done && !in_ready),
    .dig_in(core_digest), .sha(launch.sha), .rd_idx(widx[2:0]), .rd_word(dig_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_idle <= 1'b0; cfg_irq_en <= 1'b0; cfg_dma <= 1'b0;
    end else if (srst_busy) begin
      cfg_idle <= 1'b0; cfg_irq_en <= 1'b0; cfg_dma <= 1'b0;
    end else if (cfg_wr) begin
      cfg_idle <= bus_wdata[0]; cfg_irq_en <= bus_wdata[2]; cfg_dma <= bus_wdata[3];
    end
  end

  assign core_sha   = launch.sha;
  assign core_init  = launch.init;
  assign core_close = launch.close;
  assign core_len   = launch.len;
  assign irq_n      = !(out_ready && cfg_irq_en);

  always_comb begin
    bus_rdata = '0;
    if (widx < IX_COUNT) bus_rdata = dig_word;
    else begin
      case (widx)
        IX_COUNT: bus_rdata = count;
        IX_CTRL:  bus_rdata = {(32-5-LEN_W)'(0), ctl.len, ctl.close, ctl.init, ctl.sha,
                               in_ready, out_ready};
        IX_REV:   bus_rdata = {24'd0, REV_MAJOR, REV_MINOR};
        IX_CFG:   bus_rdata = {28'd0, cfg_dma, cfg_irq_en, srst_busy, cfg_idle};
        IX_STAT:  bus_rdata = {31'd0, !srst_busy};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/hashfe_chk.sv
module hashfe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        core_start,
  input logic        core_done,
  input logic        in_ready,
  input logic        out_ready,
  input logic        irq_n,
  input logic        irq_en,
  input logic        fire,
  input logic        srst_busy,
  input logic [31:0] count
);
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  // R3
  fire_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> in_ready);
  // R6
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !in_ready);
  // R7
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && !in_ready && !srst_busy) |=> out_ready);
  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (out_ready && irq_en));
  // R10
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |=> (count == 32'd0 && !out_ready && in_ready));
endmodule

bind hashfe_top hashfe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_start(core_start), .core_done(core_done),
  .in_ready(in_ready), .out_ready(out_ready), .irq_n(irq_n), .irq_en(cfg_irq_en),
  .fire(fire), .srst_busy(srst_busy), .count(count));

// File: tb/hashfe_top_tb.sv
module hashfe_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SRST_N     = 3;
  localparam int CORE_LAT   = 6;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0, bus_rdata;
  logic         irq_n, core_start, core_sha, core_init, core_close, core_done;
  logic [6:0]   core_len;
  logic [31:0]  core_count;
  logic [511:0] core_block;
  logic [159:0] core_digest;
  int           n_chk = 0, n_bad = 0, lat = 0;
  bit           finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hashfe_top #(.SRST_CYC(SRST_N), .REV_MAJOR(4'd5), .REV_MINOR(4'd9)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n),
    .core_start(core_start), .core_sha(core_sha), .core_init(core_init),
    .core_close(core_close), .core_len(core_len), .core_count(core_count),
    .core_block(core_block), .core_done(core_done), .core_digest(core_digest));

  assign core_digest = {32'hCAFEF00D, 32'h0BADBEEF, 32'h55667788, 32'hA1B2C3D4, 32'h11223344};

  always @(posedge clk) begin
    core_done <= 1'b0;
    if (!rst_n) lat <= 0;
    else if (core_start) lat <= CORE_LAT;
    else if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) core_done <= 1'b1;
    end
  end

  function automatic logic [31:0] mkctl(int len, bit cl, bit ini, bit sha);
    return (32'(len) << 5) | (32'(cl) << 4) | (32'(ini) << 3) | (32'(sha) << 2);
  endfunction
  function automatic logic [31:0] swap(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic logic [31:0] blkw(int k);
    return core_block[k*32 +: 32];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    bit ok = 0;
    for (int i = 0; i < 40 && !ok; i++) begin
      rd(8'h18, v);
      ok = v[1];
    end
    check("R6 input ready returns", 32'(ok), 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h18, v); check("R1 ctrl", v, 32'h2);
    rd(8'h14, v); check("R1 count", v, 32'h0);
    rd(8'h64, v); check("R1 status", v, 32'h1);
    check("R1 irq_n", 32'(irq_n), 32'd1);
    rd(8'h5C, v); check("R2 revision", v, 32'h59);
    wr(8'h60, 32'h9);
    rd(8'h60, v); check("R11 config readback", v, 32'h9);
    wr(8'h15, 32'h77);
    rd(8'h14, v); check("R11 unaligned ignored", v, 32'h0);
  endtask

  task automatic t_sha_full();
    logic [31:0] v;
    wr(8'h18, mkctl(64, 0, 1, 1));
    for (int k = 0; k < 15; k++) wr(8'(8'h1C + 4*k), 32'h1000_0000 + 32'(k));
    check("R3 no start before last word", 32'(core_start), 32'd0);
    wr(8'h58, 32'h1000_000F);
    check("R3 start on word 15", 32'(core_start), 32'd1);
    check("R4 len", 32'(core_len), 32'd64);
    check("R4 flags sha/init/close", {29'd0, core_sha, core_init, core_close}, 32'h6);
    check("R5 count to core", core_count, 32'd0);
    check("R3 block word0", blkw(0), 32'h1000_0000);
    check("R3 block word15", blkw(15), 32'h1000_000F);
    rd(8'h18, v);
    check("R6 input ready low", 32'(v[1]), 32'd0);
    check("R3 single pulse", 32'(core_start), 32'd0);
    wait_done();
    rd(8'h14, v); check("R5 count advanced", v, 32'd64);
    rd(8'h18, v); check("R7 output ready set", v, mkctl(64, 0, 1, 1) | 32'h3);
    check("R8 irq masked", 32'(irq_n), 32'd1);
    wr(8'h60, 32'h4);
    check("R8 irq asserted", 32'(irq_n), 32'd0);
    wr(8'h18, mkctl(64, 0, 1, 1));
    rd(8'h18, v); check("R7 write 0 keeps flag", 32'(v[0]), 32'd1);
    rd(8'h00, v); check("R9 sha word0", v, swap(32'h11223344));
    rd(8'h10, v); check("R9 sha word4", v, swap(32'hCAFEF00D));
    wr(8'h18, mkctl(64, 0, 1, 1) | 32'h1);
    rd(8'h18, v); check("R7 w1c clears", 32'(v[0]), 32'd0);
    check("R8 irq released", 32'(irq_n), 32'd1);
  endtask

  task automatic t_md5_short();
    logic [31:0] v;
    wr(8'h14, 32'd64);
    wr(8'h18, mkctl(9, 1, 0, 0));
    wr(8'h1C, 32'hAAAA_0000);
    wr(8'h20, 32'hAAAA_0001);
    check("R3 no start at word1 len9", 32'(core_start), 32'd0);
    wr(8'h24, 32'hAAAA_0002);
    check("R3 start at word2 len9", 32'(core_start), 32'd1);
    check("R4 len 9", 32'(core_len), 32'd9);
    check("R4 flags md5/close", {29'd0, core_sha, core_init, core_close}, 32'h1);
    check("R5 restored count", core_count, 32'd64);
    check("R3 old word kept", blkw(3), 32'h1000_0003);
    wr(8'h24, 32'hDEAD_0002);
    check("R6 busy no start", 32'(core_start), 32'd0);
    check("R6 busy write ignored", blkw(2), 32'hAAAA_0002);
    wait_done();
    rd(8'h14, v); check("R5 count 73", v, 32'd73);
    rd(8'h00, v); check("R9 md5 word0", v, 32'h11223344);
    rd(8'h10, v); check("R9 md5 word4 zero", v, 32'h0);
    wr(8'h18, 32'h1);
  endtask

  task automatic t_lengths();
    wr(8'h18, mkctl(12, 1, 0, 1));
    wr(8'h1C, 32'h1); wr(8'h20, 32'h2);
    check("R3 len12 no early start", 32'(core_start), 32'd0);
    wr(8'h24, 32'h3);
    check("R3 len12 start word2", 32'(core_start), 32'd1);
    check("R4 len 12", 32'(core_len), 32'd12);
    wait_done(); wr(8'h18, 32'h1);
    wr(8'h18, mkctl(0, 1, 0, 0));
    wr(8'h1C, 32'h9);
    check("R3 len0 start word0", 32'(core_start), 32'd1);
    wait_done(); wr(8'h18, 32'h1);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    int zeros = 0;
    bit up = 0;
    wr(8'h14, 32'h55);
    wr(8'h18, mkctl(20, 1, 1, 1));
    wr(8'h60, 32'h6);
    for (int i = 0; i < 20 && !up; i++) begin
      rd(8'h64, v);
      if (v[0]) up = 1; else zeros++;
    end
    check("R10 reset window", 32'(zeros), 32'(SRST_N - 1));
    rd(8'h60, v); check("R10 config cleared", v, 32'h0);
    rd(8'h14, v); check("R10 count cleared", v, 32'h0);
    rd(8'h18, v); check("R10 ctrl cleared", v, 32'h2);
    rd(8'h00, v); check("R10 digest cleared", v, 32'h0);
    check("R10 data cleared", 32'(core_block == '0), 32'd1);
    check("R10 irq idle", 32'(irq_n), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sha_full();
    t_md5_short();
    t_lengths();
    t_srst();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule